// File: doc/BRIEF.md
# Wrap and Hybrid Burst Column Address Generator

This block produces the column address for every data beat of one memory burst inside a single row of a pseudo-static memory. A row holds 2048 bytes in byte-wide mode or 1024 words in word-wide mode. A controller pulses a load strobe together with a start row, a start column and the burst configuration. It then pulses an advance strobe once per data beat. Each beat carries two units, so the column moves in steps of two.

Three orderings are supported:
- **Plain wrap** circles inside an aligned window of 16, 32 or 64 units, or the whole row.
- **Hybrid** walks the aligned window once, wrapped around the start point. It then climbs linearly from the end of the window to the top of the row and continues by wrapping over the whole row.
- **Linear** commands ignore the window setting and use the full row. A linear read that has row crossing enabled steps into the next row instead of wrapping, and a one-cycle flag marks that crossing so the controller can insert a wait state.

The configuration is captured at load. Before the first load, the block behaves as if it had been loaded with hybrid ordering, a 32-unit window, row 0 and column 0.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset, `row_o` = 0, `col_o` = 0 and `cross_o` = 0. Until the first load, advancing follows hybrid ordering with a 32-unit window starting at column 0, so beat 16 yields column 32.
- R2: A load sets `row_o` to the start row one cycle later. It also sets `col_o` to the start column with bit 0 forced to 0. A load takes priority over an advance in the same cycle.
- R3: Each cycle with `adv_i` high and `load_i` low moves the address to the next beat. With neither strobe high, `row_o` and `col_o` hold their values.
- R4: With `hybrid_i` = 0, the column wraps inside an aligned window selected by `win_len_i`: 00 = 16, 01 = 32, 10 = 64, 11 = full row. Units are bytes in byte-wide mode and words in word-wide mode.
- R5: With `hybrid_i` = 1 and a window smaller than the row, the first window/2 beats wrap inside the aligned window. The next beat goes to the window base plus the window size. Beats after that increment through the row and wrap modulo the row size. With a full-row window, hybrid ordering equals plain wrap.
- R6: With `linear_i` = 1, the window setting is ignored and the burst behaves as a full-row wrap.
- R7: The row advances only when `linear_i`, `rd_i` and `rbx_en_i` were all 1 at load and an advance leaves the last column (0x7FE in byte-wide mode, 0x3FE in word-wide mode). The column then becomes 0 and the row increments, with the top row wrapping to row 0.
- R8: `cross_o` is high for exactly the one cycle in which the new row first appears on `row_o`, and low otherwise.
- R9: Every other burst that leaves the last column returns to column 0 of the same row, including a linear write and a linear read with row crossing disabled.
- R10: With `wide_i` = 1 at load, the row spans 1024 words, and column bit 10 is forced to 0 and stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Start a new burst |
| start_row_i | input | ROW_W (14) | Start row |
| start_col_i | input | COL_W (11) | Start column |
| hybrid_i | input | 1 | 1 = hybrid ordering, 0 = plain wrap |
| win_len_i | input | 2 | Window code: 00 = 16, 01 = 32, 10 = 64, 11 = full row |
| linear_i | input | 1 | Linear command: forces a full-row window |
| rbx_en_i | input | 1 | Allow linear reads to cross into the next row |
| rd_i | input | 1 | Burst is a read |
| wide_i | input | 1 | Word-wide mode: 1024-unit row |
| adv_i | input | 1 | One data beat consumed |
| row_o | output | ROW_W (14) | Current row |
| col_o | output | COL_W (11) | Current column |
| cross_o | output | 1 | One-cycle flag on entry to a new row |

## Verification
Seeded random bursts cover every combination of ordering, window code, linear flag, read flag, crossing enable and width. Start columns are either uniform or clustered near the top of the row. Each beat is compared with a closed-form beat-index formula, and the formula differs per mode, so a window mistake in plain wrap, a wrong hand-off point in hybrid ordering, and a missing or spurious row step all show up as distinct mismatches. Directed cases separate the cases the random mix reaches only rarely:
- the top-row wrap;
- a crossing-enabled write, which must not cross;
- an odd start column;
- a load arriving in the same cycle as an advance;
- the default ordering used before any load.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

    localparam int unsigned BA_COL_W = 11;
    localparam int unsigned BA_ROW_W = 14;

    typedef enum logic [1:0] {
        WIN_16  = 2'b00,
        WIN_32  = 2'b01,
        WIN_64  = 2'b10,
        WIN_ROW = 2'b11
    } win_len_e;

    typedef struct packed {
        logic     hybrid;
        win_len_e len;
        logic     linear;
        logic     rbx_en;
        logic     is_read;
        logic     wide;
    } burst_cfg_t;

    localparam burst_cfg_t CFG_DEFAULT = '{
        hybrid:  1'b1,
        len:     WIN_32,
        linear:  1'b0,
        rbx_en:  1'b0,
        is_read: 1'b0,
        wide:    1'b0
    };

    // Window size in units for the sub-row codes; 0 means full row.
    function automatic int unsigned win_units(input win_len_e l);
        case (l)
            WIN_16:  return 16;
            WIN_32:  return 32;
            WIN_64:  return 64;
            default: return 0;
        endcase
    endfunction

    function automatic logic may_cross(input burst_cfg_t c);
        return c.linear & c.rbx_en & c.is_read;
    endfunction

endpackage

// File: rtl/burst_cfg_latch.sv
module burst_cfg_latch
    import burst_addr_pkg::*;
#(
    parameter int unsigned COL_W = BA_COL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  burst_cfg_t       cfg_i,
    input  logic [COL_W-1:0] col_i,
    output logic [COL_W-1:0] col_masked_o,
    output burst_cfg_t       cfg_q_o,
    output logic [COL_W-1:0] start_q_o
);
    // Force the start column even, and clear the top bit in word-wide mode.
    always_comb begin
        col_masked_o    = col_i;
        col_masked_o[0] = 1'b0;
        if (cfg_i.wide) begin
            col_masked_o[COL_W-1] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q_o   <= CFG_DEFAULT;
            start_q_o <= '0;
        end else if (load_i) begin
            cfg_q_o   <= cfg_i;
            start_q_o <= col_masked_o;
        end
    end

endmodule

// File: rtl/burst_col_step.sv
module burst_col_step
    import burst_addr_pkg::*;
#(
    parameter int unsigned COL_W = BA_COL_W
) (
    input  burst_cfg_t       cfg_i,
    input  logic [COL_W-1:0] col_i,
    input  logic [COL_W-1:0] start_i,
    input  logic             first_i,
    output logic [COL_W-1:0] col_n_o,
    output logic             first_n_o,
    output logic             at_last_o
);
    localparam logic [COL_W-1:0] FULL_MASK = '1;
    localparam logic [COL_W-1:0] HALF_MASK = FULL_MASK >> 1;
    localparam logic [COL_W-1:0] ONE       = COL_W'(1);
    localparam logic [COL_W-1:0] TWO       = COL_W'(2);

    logic [COL_W-1:0] row_mask;
    logic [COL_W-1:0] win_mask;
    logic [COL_W-1:0] base;
    logic [COL_W-1:0] inc;
    logic [COL_W-1:0] wrapped;
    logic [COL_W-1:0] win_end;
    logic             full_win;

    always_comb begin
        row_mask = cfg_i.wide ? HALF_MASK : FULL_MASK;
        full_win = cfg_i.linear | (cfg_i.len == WIN_ROW);
        win_mask = full_win ? row_mask : COL_W'(win_units(cfg_i.len) - 1);
        base     = col_i & ~win_mask;
        inc      = (col_i + TWO) & row_mask;
        wrapped  = base | (inc & win_mask);
        win_end  = (base + win_mask + ONE) & row_mask;
        at_last_o = (col_i == (row_mask & ~ONE));

        col_n_o   = wrapped;
        first_n_o = first_i;
        if (cfg_i.hybrid && !full_win) begin
            if (!first_i) begin
                col_n_o = inc;
            end else if (wrapped == start_i) begin
                // First window pass complete: climb from the window end.
                col_n_o   = win_end;
                first_n_o = 1'b0;
            end
        end
    end

endmodule

// File: rtl/burst_row_step.sv
module burst_row_step
    import burst_addr_pkg::*;
#(
    parameter int unsigned ROW_W = BA_ROW_W
) (
    input  logic [ROW_W-1:0] row_i,
    output logic [ROW_W-1:0] row_n_o
);
    localparam logic [ROW_W-1:0] ROW_ONE = ROW_W'(1);

    // Natural overflow returns the top row to row 0.
    always_comb begin
        row_n_o = row_i + ROW_ONE;
    end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_addr_pkg::*;
#(
    parameter int unsigned COL_W = BA_COL_W,
    parameter int unsigned ROW_W = BA_ROW_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [ROW_W-1:0] start_row_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic             hybrid_i,
    input  logic [1:0]       win_len_i,
    input  logic             linear_i,
    input  logic             rbx_en_i,
    input  logic             rd_i,
    input  logic             wide_i,
    input  logic             adv_i,
    output logic [ROW_W-1:0] row_o,
    output logic [COL_W-1:0] col_o,
    output logic             cross_o
);
    burst_cfg_t       cfg_in;
    burst_cfg_t       cfg_q;
    logic [COL_W-1:0] start_q;
    logic [COL_W-1:0] start_masked;
    logic [COL_W-1:0] col_q;
    logic [COL_W-1:0] col_n;
    logic [ROW_W-1:0] row_q;
    logic [ROW_W-1:0] row_n;
    logic             first_q;
    logic             first_n;
    logic             at_last;
    logic             cross_q;
    logic             cross_take;

    always_comb begin
        cfg_in.hybrid  = hybrid_i;
        cfg_in.len     = win_len_e'(win_len_i);
        cfg_in.linear  = linear_i;
        cfg_in.rbx_en  = rbx_en_i;
        cfg_in.is_read = rd_i;
        cfg_in.wide    = wide_i;
    end

    burst_cfg_latch #(.COL_W(COL_W)) cfg_i0 (
        .clk          (clk),
        .rst          (rst),
        .load_i       (load_i),
        .cfg_i        (cfg_in),
        .col_i        (start_col_i),
        .col_masked_o (start_masked),
        .cfg_q_o      (cfg_q),
        .start_q_o    (start_q)
    );

    burst_col_step #(.COL_W(COL_W)) col_i0 (
        .cfg_i     (cfg_q),
        .col_i     (col_q),
        .start_i   (start_q),
        .first_i   (first_q),
        .col_n_o   (col_n),
        .first_n_o (first_n),
        .at_last_o (at_last)
    );

    burst_row_step #(.ROW_W(ROW_W)) row_i0 (
        .row_i   (row_q),
        .row_n_o (row_n)
    );

    assign cross_take = adv_i & at_last & may_cross(cfg_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            row_q   <= '0;
            col_q   <= '0;
            first_q <= 1'b1;
            cross_q <= 1'b0;
        end else if (load_i) begin
            row_q   <= start_row_i;
            col_q   <= start_masked;
            first_q <= 1'b1;
            cross_q <= 1'b0;
        end else if (adv_i) begin
            col_q   <= col_n;
            first_q <= first_n;
            cross_q <= cross_take;
            if (cross_take) begin
                row_q <= row_n;
            end
        end else begin
            cross_q <= 1'b0;
        end
    end

    assign row_o   = row_q;
    assign col_o   = col_q;
    assign cross_o = cross_q;

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
    parameter int unsigned COL_W = 11,
    parameter int unsigned ROW_W = 14
) (
    input logic             clk,
    input logic             rst,
    input logic             load_i,
    input logic [ROW_W-1:0] start_row_i,
    input logic [COL_W-1:0] start_col_i,
    input logic             wide_i,
    input logic             adv_i,
    input logic [ROW_W-1:0] row_o,
    input logic [COL_W-1:0] col_o,
    input logic             cross_o
);
    logic wide_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            wide_seen <= 1'b0;
        end else if (load_i) begin
            wide_seen <= wide_i;
        end
    end

    p_load_start_r2: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (row_o == $past(start_row_i)) && !col_o[0]
                   && (col_o[COL_W-2:1] == $past(start_col_i[COL_W-2:1])));

    p_even_col_r2: assert property (@(posedge clk) disable iff (rst)
        !col_o[0]);

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !adv_i) |=> ($stable(col_o) && $stable(row_o)));

    p_row_only_by_cross_r7: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> (cross_o || $stable(row_o)));

    p_cross_after_adv_r8: assert property (@(posedge clk) disable iff (rst)
        cross_o |-> ($past(adv_i) && (col_o == '0)));

    p_cross_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        cross_o |=> !cross_o);

    p_word_top_bit_r10: assert property (@(posedge clk) disable iff (rst)
        wide_seen |-> !col_o[COL_W-1]);

endmodule

bind burst_addr_gen burst_addr_gen_chk #(.COL_W(COL_W), .ROW_W(ROW_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .load_i      (load_i),
    .start_row_i (start_row_i),
    .start_col_i (start_col_i),
    .wide_i      (wide_i),
    .adv_i       (adv_i),
    .row_o       (row_o),
    .col_o       (col_o),
    .cross_o     (cross_o)
);

// File: tb/burst_addr_gen_tb.sv
`timescale 1ns/1ps
module burst_addr_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_i = 1'b0;
    logic [13:0] start_row_i = '0;
    logic [10:0] start_col_i = '0;
    logic        hybrid_i = 1'b0;
    logic [1:0]  win_len_i = 2'b00;
    logic        linear_i = 1'b0;
    logic        rbx_en_i = 1'b0;
    logic        rd_i = 1'b0;
    logic        wide_i = 1'b0;
    logic        adv_i = 1'b0;
    logic [13:0] row_o;
    logic [10:0] col_o;
    logic        cross_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    burst_addr_gen dut_i (
        .clk(clk), .rst(rst), .load_i(load_i), .start_row_i(start_row_i),
        .start_col_i(start_col_i), .hybrid_i(hybrid_i), .win_len_i(win_len_i),
        .linear_i(linear_i), .rbx_en_i(rbx_en_i), .rd_i(rd_i), .wide_i(wide_i),
        .adv_i(adv_i), .row_o(row_o), .col_o(col_o), .cross_o(cross_o)
    );

    task automatic check(input string tag, input int er, input int ec, input bit ex);
        n_checks++;
        if (row_o !== 14'(er) || col_o !== 11'(ec) || cross_o !== ex) begin
            n_fails++;
            $display("FAIL %s: row/col/cross actual %0h/%0h/%0b expected %0h/%0h/%0b",
                     tag, row_o, col_o, cross_o, er, ec, ex);
        end
    endtask

    // Closed-form expected column for beat k of a burst.
    function automatic int exp_col(int s, bit hyb, int bl, bit lin, bit cr, bit wide, int k);
        int rs = wide ? 1024 : 2048;
        int l  = (lin || bl == 3) ? rs : (16 << bl);
        int base = s & ~(l - 1);
        int off  = s - base;
        if (cr) return (s + 2 * k) % rs;
        if (hyb && l < rs && k >= l / 2) return (base + l + 2 * (k - l / 2)) % rs;
        return base + ((off + 2 * k) % l);
    endfunction

    task automatic run_burst(input int r, input int c, input bit hyb, input int bl,
                             input bit lin, input bit rbx, input bit rd, input bit wide,
                             input int n, input string forced_tag);
        int s, rs, a;
        bit cr;
        string tag;
        rs = wide ? 1024 : 2048;
        s  = c & ~1;
        if (wide) s = s & 11'h3FF;
        cr = lin && rbx && rd;
        if (forced_tag != "") tag = forced_tag;
        else if (cr) tag = "R7";
        else if (lin) tag = "R6";
        else if (hyb) tag = "R5";
        else tag = "R4";
        @(negedge clk);
        load_i = 1'b1; start_row_i = 14'(r); start_col_i = 11'(c);
        hybrid_i = hyb; win_len_i = 2'(bl); linear_i = lin; rbx_en_i = rbx;
        rd_i = rd; wide_i = wide; adv_i = 1'b0;
        @(negedge clk);
        load_i = 1'b0;
        check("R2", r, s, 1'b0);
        for (int k = 1; k <= n; k++) begin
            adv_i = 1'b1;
            @(negedge clk);
            a = s + 2 * k;
            check(tag, cr ? ((r + a / rs) % 16384) : r,
                  exp_col(s, hyb, bl, lin, cr, wide, k),
                  cr && (a % rs == 0));
        end
        adv_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", 0, 0, 1'b0);
        // R1: default is hybrid with a 32-unit window.
        for (int k = 1; k <= 18; k++) begin
            adv_i = 1'b1;
            @(negedge clk);
            check("R1", 0, exp_col(0, 1'b1, 1, 1'b0, 1'b0, 1'b0, k), 1'b0);
        end
        adv_i = 1'b0;

        // R3: hold without strobes.
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check("R3", 0, 36, 1'b0);
        end

        // R2: odd start column forced even.
        run_burst(14'h0123, 11'h005, 1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b0, 3, "R2");

        // R2: load wins over a simultaneous advance.
        @(negedge clk);
        load_i = 1'b1; adv_i = 1'b1; start_row_i = 14'h0042; start_col_i = 11'h010;
        hybrid_i = 1'b0; win_len_i = 2'b00; linear_i = 1'b0;
        @(negedge clk);
        load_i = 1'b0; adv_i = 1'b0;
        check("R2", 14'h0042, 11'h010, 1'b0);

        // R5: start 2, window 16.
        run_burst(5, 2, 1'b1, 0, 1'b0, 1'b0, 1'b0, 1'b0, 12, "R5");
        // R4: plain wrap of 64.
        run_burst(6, 11'h07A, 1'b0, 2, 1'b0, 1'b0, 1'b1, 1'b0, 40, "R4");
        // R9: full-row plain wrap at row end, linear write, linear read without crossing.
        run_burst(7, 11'h7FC, 1'b0, 3, 1'b0, 1'b0, 1'b1, 1'b0, 4, "R9");
        run_burst(8, 11'h7FA, 1'b0, 0, 1'b1, 1'b1, 1'b0, 1'b0, 5, "R9");
        run_burst(8, 11'h7FA, 1'b1, 0, 1'b1, 1'b0, 1'b1, 1'b0, 5, "R9");
        // R6: linear read with small window code ignores it.
        run_burst(9, 11'h00C, 1'b0, 0, 1'b1, 1'b0, 1'b1, 1'b0, 12, "R6");
        // R7 / R8: top row crosses to row 0.
        run_burst(14'h3FFF, 11'h7FC, 1'b0, 1, 1'b1, 1'b1, 1'b1, 1'b0, 4, "R7");
        // R10: word-wide masking and crossing at 0x3FE.
        run_burst(10, 11'h7FE, 1'b0, 1, 1'b0, 1'b0, 1'b0, 1'b1, 2, "R10");
        run_burst(11, 11'h3FA, 1'b0, 1, 1'b1, 1'b1, 1'b1, 1'b1, 6, "R10");
        run_burst(12, 11'h3F0, 1'b1, 1, 1'b0, 1'b0, 1'b0, 1'b1, 30, "R10");

        // Seeded random mix over all modes.
        void'($urandom(32'd20240611));
        for (int i = 0; i < 260; i++) begin
            int c;
            c = ($urandom % 4 == 0) ? (32'h7C0 | ($urandom % 64)) : ($urandom % 2048);
            run_burst($urandom % 16384, c, 1'($urandom), $urandom % 4, 1'($urandom),
                      1'($urandom), 1'($urandom), 1'($urandom), 1 + ($urandom % 70), "");
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule